// File: doc/BRIEF.md
# Translation Buffer with Single-Level Table Refill

This block translates virtual addresses into physical addresses for one requester. A small fully associative buffer holds recent page translations, each tagged with the page number and the address-space identifier of the process that owns it. Every entry is searched in parallel. A request that hits returns its physical address one cycle after it is accepted, and no memory access is made.

A request that misses starts a walk. The walk reads one page-table entry from memory at the table base plus the page number. While the walk runs, the request port holds ready low. A valid entry is returned to the requester and written into the buffer. An entry marked not-present raises a fault. A page number at or beyond the table length raises a fault at once, with no memory read.

Entries can be pinned (wired) when they are loaded, so that replacement never chooses them. Software-style control inputs can flush every unpinned entry in one cycle, or remove a single translation by page number and identifier.

Top module: `tlbw_top`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and mem_rd_en are 0, and the buffer holds no translations, so the first request walks.
- R2: The page number is the upper VA_W-PAGE_BITS bits of req_vaddr and the offset is the lower PAGE_BITS bits. resp_paddr is the frame number concatenated above the unchanged offset, and it is 0 when resp_fault is 1.
- R3: A request whose page number and identifier both match a stored entry gets resp_valid with resp_hit=1 in the cycle after acceptance, and no memory read is made.
- R4: On a miss, mem_rd_en is held with mem_rd_addr = ptbr + page number until mem_rd_valid. req_ready stays 0 during the walk. The response, with resp_hit=0, comes in the cycle after mem_rd_valid.
- R5: A table entry has bit PFN_W as its present flag and bits PFN_W-1:0 as its frame. After a walk returns a present entry, the next request to the same page with the same identifier hits.
- R6: A stored translation does not match a request that carries a different identifier, even when the page number is the same.
- R7: A page number greater than or equal to ptlr gives resp_fault=1 in the cycle after acceptance, with no memory read.
- R8: A table entry with the present flag at 0 gives resp_fault=1 and is not stored, so a repeated request walks again.
- R9: Replacement is round-robin over unpinned entries, starting from entry 0 after reset. With ENTRIES translations loaded, the next refill evicts the oldest one.
- R10: A refill requested with req_wire=1 stores a pinned entry. Later refills never evict it, and flush leaves it in place.
- R11: When every entry is pinned, a walk still returns its translation but stores nothing, so repeating the request walks again.
- R12: A one-cycle flush pulse removes every unpinned entry.
- R13: An inv_en pulse removes the entry that matches inv_vpn and inv_asid, pinned or not, so the next request for it walks.
- R14: resp_hit and resp_fault are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be accepted (low during a walk) |
| req_vaddr | input | VA_W | Virtual address |
| req_asid | input | ASID_W | Address-space identifier of the request |
| req_wire | input | 1 | Pin the entry stored by this request's refill |
| ptbr | input | MEM_AW | Page-table base address |
| ptlr | input | VA_W-PAGE_BITS+1 | Number of legal pages |
| mem_rd_en | output | 1 | Table read request, held until mem_rd_valid |
| mem_rd_addr | output | MEM_AW | Table entry address |
| mem_rd_valid | input | 1 | Table read data valid |
| mem_rd_data | input | PA_W-PAGE_BITS+1 | Table entry: present flag above the frame number |
| flush | input | 1 | Remove all unpinned entries |
| inv_en | input | 1 | Remove one translation |
| inv_vpn | input | VA_W-PAGE_BITS | Page number to remove |
| inv_asid | input | ASID_W | Identifier to remove |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Response came from the buffer |
| resp_fault | output | 1 | Out-of-range page or not-present entry |
| resp_paddr | output | PA_W | Physical address |

## Verification
The bench uses the default parameters: 16-bit virtual and physical addresses, 256-byte pages, 4-bit identifiers and four buffer entries, with a table length of 64 pages. Four entries let a handful of requests fill the buffer and force eviction. They also let three pinned refills plus one earlier pinned entry leave no slot free, so the all-pinned path can be reached. An 8-bit page number can go past the length register, and the bench's memory model answers after two cycles, so the stall window and the hold on the read address can be observed.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
   typedef enum logic [0:0] {
      WS_IDLE = 1'b0,
      WS_WALK = 1'b1
   } walk_state_e;
endpackage

// File: rtl/tlbw_cam.sv
module tlbw_cam #(
   parameter int ENTRIES = 4,
   parameter int VPN_W   = 8,
   parameter int ASID_W  = 4,
   parameter int PFN_W   = 8,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              lk_hit,
   output logic [PFN_W-1:0]  lk_pfn,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [PFN_W-1:0]  wr_pfn,
   input  logic              wr_wired,
   input  logic              flush,
   input  logic              inv_en,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic [ASID_W-1:0] inv_asid,
   output logic [ENTRIES-1:0] wired_vec
);
   logic [ENTRIES-1:0] valid_q, wired_q, match;
   logic [VPN_W-1:0]   vpn_q  [ENTRIES];
   logic [ASID_W-1:0]  asid_q [ENTRIES];
   logic [PFN_W-1:0]   pfn_q  [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         wired_q <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            vpn_q[i]  <= '0;
            asid_q[i] <= '0;
            pfn_q[i]  <= '0;
         end
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
               valid_q[i] <= 1'b1;
               wired_q[i] <= wr_wired;
               vpn_q[i]   <= wr_vpn;
               asid_q[i]  <= wr_asid;
               pfn_q[i]   <= wr_pfn;
            end
            if (flush && !wired_q[i]) valid_q[i] <= 1'b0;
            if (inv_en && valid_q[i] && vpn_q[i] == inv_vpn && asid_q[i] == inv_asid) begin
               valid_q[i] <= 1'b0;
               wired_q[i] <= 1'b0;
            end
         end
      end
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn) && (asid_q[g] == lk_asid);
   end

   always_comb begin
      lk_pfn = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (match[i]) lk_pfn = lk_pfn | pfn_q[i];
   end

   assign lk_hit    = |match;
   assign wired_vec = wired_q;

   // refill only happens on a miss, so two entries never share a tag (R5)
   assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
endmodule

// File: rtl/tlbw_victim.sv
module tlbw_victim #(
   parameter int ENTRIES = 4,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] wired_vec,
   input  logic               adv,
   output logic [IDX_W-1:0]   victim_idx,
   output logic               victim_ok
);
   logic [IDX_W-1:0] ptr_q, ptr_next;

   always_comb begin
      victim_ok  = 1'b0;
      victim_idx = '0;
      for (int k = ENTRIES - 1; k >= 0; k--) begin
         int j;
         j = int'(ptr_q) + k;
         if (j >= ENTRIES) j = j - ENTRIES;
         if (!wired_vec[j]) begin
            victim_ok  = 1'b1;
            victim_idx = IDX_W'(j);
         end
      end
   end

   if ((1 << IDX_W) == ENTRIES) begin : g_pow2_wrap
      assign ptr_next = victim_idx + 1'b1;
   end else begin : g_cmp_wrap
      assign ptr_next = (victim_idx == IDX_W'(ENTRIES - 1)) ? '0 : victim_idx + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr_q <= '0;
      else if (adv) ptr_q <= ptr_next;
   end
endmodule

// File: rtl/tlbw_walker.sv
module tlbw_walker
   import tlbw_pkg::*;
#(
   parameter int VPN_W  = 8,
   parameter int PFN_W  = 8,
   parameter int MEM_AW = 16,
   localparam int PTE_W = PFN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VPN_W-1:0]  start_vpn,
   input  logic [MEM_AW-1:0] ptbr,
   output logic              busy,
   output logic              mem_rd_en,
   output logic [MEM_AW-1:0] mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [PTE_W-1:0]  mem_rd_data,
   output logic              done,
   output logic              done_present,
   output logic [PFN_W-1:0]  done_pfn
);
   walk_state_e       state_q;
   logic [MEM_AW-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WS_IDLE;
         addr_q  <= '0;
      end else begin
         case (state_q)
            WS_IDLE: if (start) begin
               state_q <= WS_WALK;
               addr_q  <= ptbr + MEM_AW'(start_vpn);
            end
            WS_WALK: if (mem_rd_valid) state_q <= WS_IDLE;
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   assign busy         = (state_q == WS_WALK);
   assign mem_rd_en    = busy;
   assign mem_rd_addr  = addr_q;
   assign done         = busy && mem_rd_valid;
   assign done_present = mem_rd_data[PFN_W];
   assign done_pfn     = mem_rd_data[PFN_W-1:0];

   // read request stays up with a steady address until the data returns (R4)
   assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr)));
endmodule

// File: rtl/tlbw_top.sv
module tlbw_top #(
   parameter int VA_W      = 16,
   parameter int PAGE_BITS = 8,
   parameter int PA_W      = 16,
   parameter int ASID_W    = 4,
   parameter int ENTRIES   = 4,
   parameter int MEM_AW    = 16,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int PFN_W    = PA_W - PAGE_BITS,
   localparam int PTE_W    = PFN_W + 1,
   localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic [ASID_W-1:0] req_asid,
   input  logic              req_wire,
   input  logic [MEM_AW-1:0] ptbr,
   input  logic [VPN_W:0]    ptlr,
   output logic              mem_rd_en,
   output logic [MEM_AW-1:0] mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [PTE_W-1:0]  mem_rd_data,
   input  logic              flush,
   input  logic              inv_en,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic [ASID_W-1:0] inv_asid,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic              resp_fault,
   output logic [PA_W-1:0]   resp_paddr
);
   if (PAGE_BITS < 1 || PAGE_BITS >= VA_W) begin : g_bad_page
      $error("tlbw_top: PAGE_BITS must lie in 1..VA_W-1");
   end
   if (PAGE_BITS >= PA_W) begin : g_bad_pa
      $error("tlbw_top: PA_W must exceed PAGE_BITS");
   end
   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlbw_top: ENTRIES must be at least 2");
   end
   if (VPN_W > MEM_AW) begin : g_bad_aw
      $error("tlbw_top: MEM_AW must hold a page number");
   end

   logic [VPN_W-1:0]     req_vpn;
   logic [PAGE_BITS-1:0] req_off;
   logic                 accept, in_range, lk_hit, walk_start;
   logic [PFN_W-1:0]     lk_pfn;
   logic                 busy, done, done_present, victim_ok, ins_en;
   logic [PFN_W-1:0]     done_pfn;
   logic [IDX_W-1:0]     victim_idx;
   logic [ENTRIES-1:0]   wired_vec;

   logic [VPN_W-1:0]     pend_vpn;
   logic [ASID_W-1:0]    pend_asid;
   logic [PAGE_BITS-1:0] pend_off;
   logic                 pend_wire;

   assign req_vpn    = req_vaddr[VA_W-1:PAGE_BITS];
   assign req_off    = req_vaddr[PAGE_BITS-1:0];
   assign req_ready  = !busy;
   assign accept     = req_valid && req_ready;
   assign in_range   = {1'b0, req_vpn} < ptlr;
   assign walk_start = accept && in_range && !lk_hit;
   assign ins_en     = done && done_present && victim_ok;

   tlbw_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_cam (
      .clk(clk), .rst_n(rst_n),
      .lk_vpn(req_vpn), .lk_asid(req_asid), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
      .wr_en(ins_en), .wr_idx(victim_idx), .wr_vpn(pend_vpn), .wr_asid(pend_asid),
      .wr_pfn(done_pfn), .wr_wired(pend_wire),
      .flush(flush), .inv_en(inv_en), .inv_vpn(inv_vpn), .inv_asid(inv_asid),
      .wired_vec(wired_vec)
   );

   tlbw_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk(clk), .rst_n(rst_n), .wired_vec(wired_vec), .adv(ins_en),
      .victim_idx(victim_idx), .victim_ok(victim_ok)
   );

   tlbw_walker #(.VPN_W(VPN_W), .PFN_W(PFN_W), .MEM_AW(MEM_AW)) u_walker (
      .clk(clk), .rst_n(rst_n), .start(walk_start), .start_vpn(req_vpn), .ptbr(ptbr),
      .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .done(done), .done_present(done_present), .done_pfn(done_pfn)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_vpn  <= '0;
         pend_asid <= '0;
         pend_off  <= '0;
         pend_wire <= 1'b0;
      end else if (walk_start) begin
         pend_vpn  <= req_vpn;
         pend_asid <= req_asid;
         pend_off  <= req_off;
         pend_wire <= req_wire;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
         resp_fault <= 1'b0;
         resp_paddr <= '0;
      end else begin
         resp_valid <= 1'b0;
         if (accept && !in_range) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b0;
            resp_fault <= 1'b1;
            resp_paddr <= '0;
         end else if (accept && lk_hit) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_fault <= 1'b0;
            resp_paddr <= {lk_pfn, req_off};
         end else if (done) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b0;
            resp_fault <= !done_present;
            resp_paddr <= done_present ? {done_pfn, pend_off} : '0;
         end
      end
   end

   assert_no_hit_and_fault_R14: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !(resp_hit && resp_fault));
   assert_stall_in_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> !req_ready);
   assert_range_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !in_range) |=> (resp_valid && resp_fault && !mem_rd_en));
   assert_refill_has_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> !wired_vec[victim_idx]);
endmodule

// File: tb/tlbw_top_test.sv
module tlbw_top_test;
   localparam int CLK_PERIOD = 10;
   localparam int MEM_LAT    = 2;
   localparam logic [15:0] PTBR = 16'h1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_wire = 1'b0;
   logic        req_ready;
   logic [15:0] req_vaddr = '0;
   logic [3:0]  req_asid = '0;
   logic [8:0]  ptlr = 9'd64;
   logic        mem_rd_en, mem_rd_valid = 1'b0;
   logic [15:0] mem_rd_addr;
   logic [8:0]  mem_rd_data = '0;
   logic        flush = 1'b0, inv_en = 1'b0;
   logic [7:0]  inv_vpn = '0;
   logic [3:0]  inv_asid = '0;
   logic        resp_valid, resp_hit, resp_fault;
   logic [15:0] resp_paddr;

   int errors = 0, checks = 0, rd_count = 0, lat_cnt = 0;
   bit finished = 0;

   tlbw_top uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_asid(req_asid), .req_wire(req_wire),
      .ptbr(PTBR), .ptlr(ptlr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .flush(flush), .inv_en(inv_en), .inv_vpn(inv_vpn), .inv_asid(inv_asid),
      .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
      .resp_paddr(resp_paddr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [8:0] pte_of(input logic [7:0] v);
      return {v != 8'h33, v ^ 8'hA5};
   endfunction

   always @(negedge clk) begin
      if (mem_rd_valid) mem_rd_valid = 1'b0;
      else if (mem_rd_en) begin
         lat_cnt++;
         if (lat_cnt == MEM_LAT) begin
            lat_cnt = 0;
            mem_rd_valid = 1'b1;
            mem_rd_data  = pte_of(8'(mem_rd_addr - PTBR));
            rd_count++;
         end
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic do_access(input logic [7:0] vpn, input logic [3:0] asid,
                            input logic [7:0] off, input logic wire_it,
                            input bit exp_hit, input bit exp_fault,
                            input int exp_reads, input string rq);
      int rd0, lat;
      logic [15:0] exp_pa;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_vaddr = {vpn, off}; req_asid = asid; req_wire = wire_it;
      rd0 = rd_count;
      @(negedge clk);
      req_valid = 1'b0; req_wire = 1'b0;
      lat = 0;
      while (!resp_valid && lat < 100) begin
         if (mem_rd_en) begin
            chk(req_ready == 1'b0, "R4", "ready during walk", req_ready, 0);
            chk(mem_rd_addr == PTBR + 16'(vpn), "R4", "table address", mem_rd_addr, PTBR + 16'(vpn));
         end
         @(negedge clk);
         lat++;
      end
      exp_pa = exp_fault ? 16'h0 : {vpn ^ 8'hA5, off};
      chk(resp_valid == 1'b1, rq, "response seen", resp_valid, 1);
      chk(lat == (exp_reads != 0 ? MEM_LAT : 0), rq, "latency", lat, exp_reads != 0 ? MEM_LAT : 0);
      chk(resp_hit == exp_hit, rq, "hit flag", resp_hit, exp_hit);
      chk(resp_fault == exp_fault, rq, "fault flag", resp_fault, exp_fault);
      chk(resp_paddr == exp_pa, {rq, " R2"}, "physical address", resp_paddr, exp_pa);
      chk(!(resp_hit && resp_fault), "R14", "hit with fault", {resp_hit, resp_fault}, 0);
      chk(rd_count - rd0 == exp_reads, rq, "table reads", rd_count - rd0, exp_reads);
   endtask

   task automatic pulse_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
   endtask

   task automatic pulse_inv(input logic [7:0] v, input logic [3:0] a);
      @(negedge clk); inv_en = 1'b1; inv_vpn = v; inv_asid = a;
      @(negedge clk); inv_en = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
      chk(resp_valid == 1'b0, "R1", "resp_valid after reset", resp_valid, 0);
      chk(mem_rd_en == 1'b0, "R1", "mem_rd_en after reset", mem_rd_en, 0);
      do_access(8'h01, 4'd1, 8'h3C, 1'b0, 0, 0, 1, "R1");
   endtask

   task automatic t_hit_after_refill();
      do_access(8'h01, 4'd1, 8'h7E, 1'b0, 1, 0, 0, "R3 R5");
      do_access(8'h01, 4'd1, 8'h00, 1'b0, 1, 0, 0, "R3");
   endtask

   task automatic t_round_robin();
      do_access(8'h02, 4'd1, 8'h11, 1'b0, 0, 0, 1, "R4");
      do_access(8'h03, 4'd1, 8'h22, 1'b0, 0, 0, 1, "R4");
      do_access(8'h04, 4'd1, 8'h33, 1'b0, 0, 0, 1, "R4");
      do_access(8'h05, 4'd1, 8'h44, 1'b0, 0, 0, 1, "R9");
      do_access(8'h02, 4'd1, 8'h55, 1'b0, 1, 0, 0, "R9");
      do_access(8'h03, 4'd1, 8'h66, 1'b0, 1, 0, 0, "R9");
      do_access(8'h04, 4'd1, 8'h77, 1'b0, 1, 0, 0, "R9");
      do_access(8'h01, 4'd1, 8'h88, 1'b0, 0, 0, 1, "R9 oldest evicted");
   endtask

   task automatic t_asid();
      do_access(8'h03, 4'd7, 8'h12, 1'b0, 0, 0, 1, "R6");
   endtask

   task automatic t_length();
      do_access(8'h50, 4'd1, 8'h01, 1'b0, 0, 1, 0, "R7");
      do_access(8'h40, 4'd1, 8'h02, 1'b0, 0, 1, 0, "R7 boundary");
      do_access(8'h3F, 4'd1, 8'h03, 1'b0, 0, 0, 1, "R7 last legal");
   endtask

   task automatic t_not_present();
      do_access(8'h33, 4'd1, 8'h09, 1'b0, 0, 1, 1, "R8");
      do_access(8'h33, 4'd1, 8'h09, 1'b0, 0, 1, 1, "R8 not stored");
   endtask

   task automatic t_wired_flush();
      pulse_flush();
      do_access(8'h0A, 4'd1, 8'h01, 1'b1, 0, 0, 1, "R10");
      for (int v = 11; v <= 14; v++)
         do_access(8'(v), 4'd1, 8'h02, 1'b0, 0, 0, 1, "R10 fill");
      do_access(8'h0A, 4'd1, 8'h03, 1'b0, 1, 0, 0, "R10 survives refills");
      do_access(8'h0E, 4'd1, 8'h04, 1'b0, 1, 0, 0, "R12 before flush");
      pulse_flush();
      do_access(8'h0A, 4'd1, 8'h05, 1'b0, 1, 0, 0, "R10 survives flush");
      do_access(8'h0E, 4'd1, 8'h06, 1'b0, 0, 0, 1, "R12");
   endtask

   task automatic t_all_wired();
      do_access(8'h14, 4'd1, 8'h01, 1'b1, 0, 0, 1, "R10");
      do_access(8'h15, 4'd1, 8'h02, 1'b1, 0, 0, 1, "R10");
      do_access(8'h16, 4'd1, 8'h03, 1'b1, 0, 0, 1, "R10");
      do_access(8'h1E, 4'd1, 8'h04, 1'b0, 0, 0, 1, "R11");
      do_access(8'h1E, 4'd1, 8'h05, 1'b0, 0, 0, 1, "R11 not stored");
      do_access(8'h0A, 4'd1, 8'h06, 1'b0, 1, 0, 0, "R11");
      do_access(8'h15, 4'd1, 8'h07, 1'b0, 1, 0, 0, "R11");
   endtask

   task automatic t_invalidate();
      pulse_inv(8'h14, 4'd1);
      do_access(8'h14, 4'd1, 8'h08, 1'b0, 0, 0, 1, "R13");
      do_access(8'h14, 4'd1, 8'h09, 1'b0, 1, 0, 0, "R13 refilled");
      do_access(8'h16, 4'd1, 8'h0A, 1'b0, 1, 0, 0, "R13 others kept");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_hit_after_refill();
      t_round_robin();
      t_asid();
      t_length();
      t_not_present();
      t_wired_flush();
      t_all_wired();
      t_invalidate();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule